// File: doc/BRIEF.md
# AC97 Codec Register Access Sequencer

This engine performs a single codec register read or write over the command slots of an AC97 controller. The host presents a request that carries a 7-bit register index, a 16-bit value and a direction flag. The engine then loads the controller's command data and command address words and polls the controller's transmit-sent and receive-ready flags, clearing each flag after use. Every wait has a timeout, and the engine retries a failed attempt.

A read passes only when the index that comes back from the codec equals the requested index. A mismatch causes a short pause and then a fresh attempt. A read that fails on every attempt returns all ones with the error flag set. All waits are counted in ticks of a one-microsecond enable input, so the clock frequency has no effect on them. The host sees a busy level while a request runs and a one-cycle done pulse with an error flag when it ends.

Top module: `ac97_cmd_seq`

## Requirements
- R1: The command address word carries the register index in bits 18:12. Bit 19 is 1 for a read and 0 for a write. All other bits are 0.
- R2: A write loads the command data word with the value in bits 19:4 and all other bits 0. It does so in the cycle after both transmit-sent flags are cleared and in the cycle before the address load. A read never loads the data word.
- R3: A write attempt succeeds when either transmit-sent flag rises within 500 ticks. Both flags are cleared when the attempt ends, so each write attempt gives two clear pulses for each flag.
- R4: A write makes at most two attempts. If no flag rises in either attempt, the write ends with err_o=1, and a second attempt starts no sooner than 500 ticks after the first address load.
- R5: A read clears only the address-sent flag. It loads the address word with bit 19 set, waits up to 21 ticks for address-sent and then clears it, so each attempt gives two address-flag clears and no data-flag clear.
- R6: After the transmit wait, a read waits up to 500 ticks for receive-address-ready and then up to 500 ticks for receive-data-ready. If both waits expire, the attempt counts as link-down and the next attempt starts at once, at least 1021 ticks after the previous address load.
- R7: A read compares the returned index (bits 18:12 of the receive address word) with the request. On a match it ends with err_o=0 and rdata_o set to bits 19:4 of the receive data word. Both receive-ready flags are cleared once for each attempt.
- R8: After an index mismatch the engine waits at least 21 ticks before the next address load. A read makes at most 5 attempts.
- R9: A read that fails on all 5 attempts ends with err_o=1 and rdata_o=16'hFFFF.
- R10: A request is accepted only while busy_o is low. A request raised while busy_o is high is ignored and leaves the running operation unchanged.
- R11: done_o is a one-cycle pulse in the cycle busy_o falls, and err_o is valid with it.
- R12: Timeouts count tick_i pulses and not clock cycles.
- R13: After reset, busy_o, done_o, err_o, every strobe and rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond enable pulse |
| req_i | input | 1 | Start request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 7 | Codec register index |
| wval_i | input | 16 | Value to write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operation failed, valid with done_o |
| rdata_o | output | 16 | Result of the last read |
| cmd_addr_o | output | 32 | Command address word |
| cmd_addr_we_o | output | 1 | Load strobe for the command address word |
| cmd_data_o | output | 32 | Command data word |
| cmd_data_we_o | output | 1 | Load strobe for the command data word |
| tx_addr_sent_i | input | 1 | Controller: command address transmitted |
| tx_data_sent_i | input | 1 | Controller: command data transmitted |
| clr_tx_addr_o | output | 1 | Clear the address-sent flag |
| clr_tx_data_o | output | 1 | Clear the data-sent flag |
| rx_addr_rdy_i | input | 1 | Controller: status address received |
| rx_data_rdy_i | input | 1 | Controller: status data received |
| rx_addr_i | input | 32 | Received status address word |
| rx_data_i | input | 32 | Received status data word |
| clr_rx_o | output | 1 | Clear both receive-ready flags |

## Verification
The bench targets four failure modes.

- Retry limits: it drives reads whose returned index is wrong on 2, 4 and all 5 attempts. An off-by-one in the attempt counter shows up as a sixth address load, or as a pass reported in place of the all-ones failure.
- Silent codec: it holds back every flag for one or more attempts, for both writes and reads. A design that mixes up the 21- and 500-tick limits, or counts clock cycles in place of ticks, gives tick and cycle gaps between address loads that are too short.
- Flag housekeeping: it counts every clear pulse, so a missing clear or one aimed at the wrong flag is caught.
- Busy request: a second request during a running read must leave the index, the direction and the number of done pulses unchanged.

// File: rtl/ac97_seq_pkg.sv
package ac97_seq_pkg;
  localparam int IDX_W   = 7;
  localparam int VAL_W   = 16;
  localparam int WORD_W  = 32;
  localparam int IDX_LSB = 12;
  localparam int RD_BIT  = IDX_LSB + IDX_W;
  localparam int VAL_LSB = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_DATA,
    ST_ADDR,
    ST_TXW,
    ST_TXC,
    ST_RXA,
    ST_RXD,
    ST_CHK,
    ST_GAP
  } seq_st_e;
endpackage

// File: rtl/ac97_us_timer.sv
module ac97_us_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (tick_i && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/ac97_word_fmt.sv
module ac97_word_fmt
  import ac97_seq_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rd_i,
  input  logic [VAL_W-1:0]  val_i,
  input  logic [WORD_W-1:0] rx_addr_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic [WORD_W-1:0] addr_word_o,
  output logic [WORD_W-1:0] data_word_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic [VAL_W-1:0]  rx_val_o
);
  always_comb begin
    addr_word_o = '0;
    addr_word_o[IDX_LSB +: IDX_W] = idx_i;
    addr_word_o[RD_BIT] = rd_i;
    data_word_o = '0;
    data_word_o[VAL_LSB +: VAL_W] = val_i;
  end

  assign rx_idx_o = rx_addr_i[IDX_LSB +: IDX_W];
  assign rx_val_o = rx_data_i[VAL_LSB +: VAL_W];

  // bits outside the index and value fields carry nothing for this engine
  logic unused_rx;
  assign unused_rx = ^{rx_addr_i[WORD_W-1:RD_BIT], rx_addr_i[IDX_LSB-1:0],
                       rx_data_i[WORD_W-1:VAL_LSB+VAL_W], rx_data_i[VAL_LSB-1:0]};
endmodule

// File: rtl/ac97_cmd_seq.sv
module ac97_cmd_seq
  import ac97_seq_pkg::*;
#(
  parameter int WR_TMO    = 500,
  parameter int RD_TX_TMO = 21,
  parameter int RX_TMO    = 500,
  parameter int RETRY_GAP = 21,
  parameter int WR_TRIES  = 2,
  parameter int RD_TRIES  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [6:0]        idx_i,
  input  logic [15:0]       wval_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [15:0]       rdata_o,
  output logic [31:0]       cmd_addr_o,
  output logic              cmd_addr_we_o,
  output logic [31:0]       cmd_data_o,
  output logic              cmd_data_we_o,
  input  logic              tx_addr_sent_i,
  input  logic              tx_data_sent_i,
  output logic              clr_tx_addr_o,
  output logic              clr_tx_data_o,
  input  logic              rx_addr_rdy_i,
  input  logic              rx_data_rdy_i,
  input  logic [31:0]       rx_addr_i,
  input  logic [31:0]       rx_data_i,
  output logic              clr_rx_o
);
  localparam int TMAX1 = (WR_TMO > RX_TMO) ? WR_TMO : RX_TMO;
  localparam int TMAX2 = (RD_TX_TMO > RETRY_GAP) ? RD_TX_TMO : RETRY_GAP;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int CNT_W = $clog2(TMAX + 2);
  localparam int AMAX  = (WR_TRIES > RD_TRIES) ? WR_TRIES : RD_TRIES;
  localparam int ATT_W = $clog2(AMAX + 1);

  seq_st_e state_q, state_n;
  logic             wr_q, tx_ok_q, to_a_q, to_d_q, done_q, err_q;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] val_q, rdata_q;
  logic [ATT_W-1:0] att_q;
  logic [CNT_W-1:0] lim;
  logic             expired, tx_flag, hit, link_down;
  logic [IDX_W-1:0] rx_idx;
  logic [VAL_W-1:0] rx_val;

  ac97_word_fmt u_fmt (
    .idx_i       (idx_q),
    .rd_i        (!wr_q),
    .val_i       (val_q),
    .rx_addr_i   (rx_addr_i),
    .rx_data_i   (rx_data_i),
    .addr_word_o (cmd_addr_o),
    .data_word_o (cmd_data_o),
    .rx_idx_o    (rx_idx),
    .rx_val_o    (rx_val)
  );

  ac97_us_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_n != state_q),
    .tick_i    (tick_i),
    .limit_i   (lim),
    .expired_o (expired)
  );

  assign tx_flag   = tx_addr_sent_i | (wr_q & tx_data_sent_i);
  assign link_down = to_a_q & to_d_q;
  assign hit       = !link_down && (rx_idx == idx_q);

  always_comb begin
    state_n       = state_q;
    lim           = '0;
    clr_tx_addr_o = 1'b0;
    clr_tx_data_o = 1'b0;
    cmd_data_we_o = 1'b0;
    cmd_addr_we_o = 1'b0;
    clr_rx_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) state_n = ST_CLR;
      ST_CLR: begin
        clr_tx_addr_o = 1'b1;
        clr_tx_data_o = wr_q;
        state_n = wr_q ? ST_DATA : ST_ADDR;
      end
      ST_DATA: begin
        cmd_data_we_o = 1'b1;
        state_n = ST_ADDR;
      end
      ST_ADDR: begin
        cmd_addr_we_o = 1'b1;
        state_n = ST_TXW;
      end
      ST_TXW: begin
        lim = wr_q ? CNT_W'(WR_TMO) : CNT_W'(RD_TX_TMO);
        if (tx_flag || expired) state_n = ST_TXC;
      end
      ST_TXC: begin
        clr_tx_addr_o = 1'b1;
        clr_tx_data_o = wr_q;
        if (!wr_q)                                    state_n = ST_RXA;
        else if (tx_ok_q || att_q == ATT_W'(WR_TRIES)) state_n = ST_IDLE;
        else                                          state_n = ST_CLR;
      end
      ST_RXA: begin
        lim = CNT_W'(RX_TMO);
        if (rx_addr_rdy_i || expired) state_n = ST_RXD;
      end
      ST_RXD: begin
        lim = CNT_W'(RX_TMO);
        if (rx_data_rdy_i || expired) state_n = ST_CHK;
      end
      ST_CHK: begin
        clr_rx_o = 1'b1;
        if (hit || att_q == ATT_W'(RD_TRIES)) state_n = ST_IDLE;
        else if (link_down)                   state_n = ST_CLR;
        else                                  state_n = ST_GAP;
      end
      ST_GAP: begin
        lim = CNT_W'(RETRY_GAP);
        if (expired) state_n = ST_CLR;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      val_q   <= '0;
      att_q   <= '0;
      tx_ok_q <= 1'b0;
      to_a_q  <= 1'b0;
      to_d_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_n;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          wr_q  <= wr_i;
          idx_q <= idx_i;
          val_q <= wval_i;
          att_q <= '0;
        end
        ST_ADDR: att_q <= att_q + 1'b1;
        ST_TXW:  if (state_n != state_q) tx_ok_q <= tx_flag;
        ST_TXC:  if (state_n == ST_IDLE) begin
          done_q <= 1'b1;
          err_q  <= !tx_ok_q;
        end
        ST_RXA:  if (state_n != state_q) to_a_q <= !rx_addr_rdy_i;
        ST_RXD:  if (state_n != state_q) to_d_q <= !rx_data_rdy_i;
        ST_CHK:  if (state_n == ST_IDLE) begin
          done_q  <= 1'b1;
          err_q   <= !hit;
          rdata_q <= hit ? rx_val : '1;
        end
        default: ;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ac97_cmd_seq_chk.sv
module ac97_cmd_seq_chk
  import ac97_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o,
  input logic [31:0] cmd_addr_o,
  input logic        cmd_addr_we_o,
  input logic        cmd_data_we_o,
  input logic        clr_tx_addr_o,
  input logic        clr_tx_data_o
);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r2_data_before_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_addr_we_o && !cmd_addr_o[RD_BIT]) |-> $past(cmd_data_we_o));

  a_r2_no_data_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_data_we_o |-> !cmd_addr_o[RD_BIT]);

  a_r5_read_clear_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_addr_we_o && cmd_addr_o[RD_BIT]) |-> ($past(clr_tx_addr_o) && !$past(clr_tx_data_o)));

  a_r9_fail_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o && cmd_addr_o[RD_BIT]) |-> (rdata_o == 16'hFFFF));

  a_r10_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> !busy_o);
endmodule

bind ac97_cmd_seq ac97_cmd_seq_chk u_chk (.*);

// File: tb/sim_ac97_cmd_seq.sv
module sim_ac97_cmd_seq;
  typedef struct packed {
    logic        wr;
    logic [6:0]  idx;
    logic [15:0] val;
    logic [2:0]  drop;
    logic [2:0]  mism;
    logic        e_err;
    logic [2:0]  e_att;
    logic [15:0] e_rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h02, 16'h8000, 3'd0, 3'd0, 1'b0, 3'd1, 16'h0000},
    '{1'b0, 7'h7C, 16'h4144, 3'd0, 3'd0, 1'b0, 3'd1, 16'h4144},
    '{1'b0, 7'h18, 16'h0808, 3'd0, 3'd2, 1'b0, 3'd3, 16'h0808},
    '{1'b0, 7'h2A, 16'h0001, 3'd0, 3'd4, 1'b0, 3'd5, 16'h0001},
    '{1'b0, 7'h26, 16'h000F, 3'd0, 3'd5, 1'b1, 3'd5, 16'hFFFF},
    '{1'b1, 7'h7F, 16'hFFFF, 3'd1, 3'd0, 1'b0, 3'd2, 16'h0000},
    '{1'b1, 7'h04, 16'h1234, 3'd2, 3'd0, 1'b1, 3'd2, 16'h0000},
    '{1'b0, 7'h1C, 16'hA5A5, 3'd1, 3'd0, 1'b0, 3'd2, 16'hA5A5},
    '{1'b0, 7'h00, 16'h5555, 3'd5, 3'd0, 1'b1, 3'd5, 16'hFFFF},
    '{1'b0, 7'h00, 16'h0000, 3'd0, 3'd0, 1'b0, 3'd1, 16'h0000}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, req_i = 1'b0, wr_i = 1'b0;
  logic [6:0]  idx_i = '0;
  logic [15:0] wval_i = '0;
  logic busy_o, done_o, err_o, cmd_addr_we_o, cmd_data_we_o;
  logic clr_tx_addr_o, clr_tx_data_o, clr_rx_o;
  logic [15:0] rdata_o;
  logic [31:0] cmd_addr_o, cmd_data_o;
  logic tx_addr_sent_i = 1'b0, tx_data_sent_i = 1'b0;
  logic rx_addr_rdy_i = 1'b0, rx_data_rdy_i = 1'b0;
  logic [31:0] rx_addr_i = '0, rx_data_i = '0;

  ac97_cmd_seq u0 (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0, tick_cnt = 0, tdiv = 0;
  logic c_wr; logic [6:0] c_idx; logic [15:0] c_val; int c_drop, c_mism;
  int n_addr, n_data, n_ctxa, n_ctxd, n_crx, n_done;
  int last_tick, last_cyc, min_gap, min_cgap;
  int tx_cd, rx_cd;
  logic [31:0] got_aw, got_dw;
  logic got_err; logic [15:0] got_rd;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // codec/controller model, tick source and monitor
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      if (clr_tx_addr_o) begin tx_addr_sent_i = 1'b0; n_ctxa++; end
      if (clr_tx_data_o) begin tx_data_sent_i = 1'b0; n_ctxd++; end
      if (clr_rx_o) begin rx_addr_rdy_i = 1'b0; rx_data_rdy_i = 1'b0; n_crx++; end
      if (cmd_data_we_o) begin n_data++; got_dw = cmd_data_o; end
      if (done_o) begin n_done++; got_err = err_o; got_rd = rdata_o; end
      if (tx_cd > 0) begin
        tx_cd--;
        if (tx_cd == 0) begin tx_addr_sent_i = 1'b1; tx_data_sent_i = c_wr; end
      end
      if (rx_cd > 0) begin
        rx_cd--;
        if (rx_cd == 0) begin
          rx_addr_i = 32'(((n_addr - 1 - c_drop) < c_mism) ? (c_idx ^ 7'h01) : c_idx) << 12;
          rx_data_i = 32'(c_val) << 4;
          rx_addr_rdy_i = 1'b1;
          rx_data_rdy_i = 1'b1;
        end
      end
      if (cmd_addr_we_o) begin
        if (n_addr > 0) begin
          if (tick_cnt - last_tick < min_gap) min_gap = tick_cnt - last_tick;
          if (cyc - last_cyc < min_cgap) min_cgap = cyc - last_cyc;
        end
        last_tick = tick_cnt; last_cyc = cyc;
        got_aw = cmd_addr_o;
        n_addr++;
        if (n_addr - 1 >= c_drop) begin
          tx_cd = 3;
          if (!c_wr) rx_cd = 8;
        end
      end
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      tick_i = (tdiv == 2);
      if (tick_i) tick_cnt++;
    end
  end

  task automatic start_op(input logic wr, input logic [6:0] idx, input logic [15:0] val,
                          input int drop, input int mism);
    c_wr = wr; c_idx = idx; c_val = val; c_drop = drop; c_mism = mism;
    n_addr = 0; n_data = 0; n_ctxa = 0; n_ctxd = 0; n_crx = 0; n_done = 0;
    min_gap = 1 << 30; min_cgap = 1 << 30; tx_cd = 0; rx_cd = 0;
    @(negedge clk_i);
    req_i = 1'b1; wr_i = wr; idx_i = idx; wval_i = val;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    while (n_done == 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    c_wr = 1'b0; c_idx = '0; c_val = '0; c_drop = 0; c_mism = 0;
    n_addr = 0; n_data = 0; n_ctxa = 0; n_ctxd = 0; n_crx = 0; n_done = 0;
    tx_cd = 0; rx_cd = 0; last_tick = 0; last_cyc = 0;
    repeat (4) @(negedge clk_i);
    // R13 reset state
    chk(!busy_o && !done_o && !err_o, "R13", "busy/done/err", {busy_o, done_o, err_o}, 0);
    chk(rdata_o == 16'h0, "R13", "rdata", rdata_o, 0);
    chk(!cmd_addr_we_o && !cmd_data_we_o && !clr_tx_addr_o && !clr_tx_data_o && !clr_rx_o,
        "R13", "strobes", {cmd_addr_we_o, cmd_data_we_o, clr_tx_addr_o, clr_tx_data_o, clr_rx_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VEC[v];
      start_op(t.wr, t.idx, t.val, int'(t.drop), int'(t.mism));
      wait_done();
      chk(n_done == 1, "R11", "done pulses", n_done, 1);
      chk(n_addr == int'(t.e_att), t.wr ? "R4" : "R8", "attempts", n_addr, t.e_att);
      chk(got_err == t.e_err, t.wr ? "R4" : "R9", "err", got_err, t.e_err);
      chk(got_aw == ((32'(!t.wr) << 19) | (32'(t.idx) << 12)), "R1", "addr word",
          got_aw, (32'(!t.wr) << 19) | (32'(t.idx) << 12));
      if (t.wr) begin
        chk(n_data == n_addr && got_dw == (32'(t.val) << 4), "R2", "data word",
            got_dw, 32'(t.val) << 4);
        chk(n_ctxa == 2 * n_addr && n_ctxd == 2 * n_addr, "R3", "tx clears",
            n_ctxd, 2 * n_addr);
        if (t.drop != 0) begin
          chk(min_gap >= 500, "R4", "retry tick gap", min_gap, 500);
          chk(min_cgap >= 1500, "R12", "retry cycle gap", min_cgap, 1500);
        end
      end else begin
        chk(got_rd == t.e_rd, t.e_err ? "R9" : "R7", "rdata", got_rd, t.e_rd);
        chk(n_data == 0 && n_ctxd == 0 && n_ctxa == 2 * n_addr, "R5", "read clears",
            n_ctxa, 2 * n_addr);
        chk(n_crx == n_addr, "R7", "rx clears", n_crx, n_addr);
        if (t.mism != 0) chk(min_gap >= 21, "R8", "mismatch gap", min_gap, 21);
        if (t.drop != 0) chk(min_gap >= 1021, "R6", "link-down gap", min_gap, 1021);
      end
    end

    // R10 request while busy is ignored
    start_op(1'b0, 7'h31, 16'h0BAD, 0, 0);
    repeat (2) @(negedge clk_i);
    chk(busy_o == 1'b1, "R10", "busy during op", busy_o, 1);
    req_i = 1'b1; wr_i = 1'b1; idx_i = 7'h11; wval_i = 16'h7777;
    @(negedge clk_i);
    req_i = 1'b0;
    wait_done();
    repeat (20) @(negedge clk_i);
    chk(n_done == 1 && !busy_o, "R10", "done count after busy req", n_done, 1);
    chk(n_addr == 1 && n_data == 0, "R10", "loads after busy req", n_addr, 1);
    chk(got_aw == ((32'd1 << 19) | (32'h31 << 12)), "R10", "addr word kept",
        got_aw, (32'd1 << 19) | (32'h31 << 12));
    chk(got_rd == 16'h0BAD && !got_err, "R10", "read result", got_rd, 16'h0BAD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule